// File: doc/BRIEF.md
# IDE Bus-Master DMA Register Bank

This block keeps the bus-master control state for a number of IDE channels (two by default): a command byte, a status byte and a descriptor table pointer per channel, plus two spare storage bytes per channel. Software reaches them through a byte-addressed register port that writes one, two or four bytes and reads four bytes at once. The block does not move data. It tells each drive's DMA engine when to start or abort, hands over the descriptor pointer, and turns the engine's completion into a per-channel interrupt.

A start or abort only happens when a command write changes the run bit. The drive that receives the pulse is the one named by that channel's drive-select input. While a transfer is running, the direction bit is locked. In the status byte the active flag is read-only to software. The interrupt and error flags are cleared by writing a one. The remaining status bits are plain storage.

Each channel occupies 8 bytes of address space. Channel c starts at byte 8*c. Within a channel: offset 0 is command (run = bit 0, direction = bit 3), offset 2 is status (active = bit 0, error = bit 1, interrupt = bit 2, drive-capable flags = bits 5 and 6), offset 4 is the 32-bit pointer (little-endian), and offsets 1 and 3 are spare bytes. Offsets 5 to 7 cannot be written. Write size codes on `wr_size` are 0 = one byte, 1 = two bytes, 2 = four bytes.

Top module: `bmdma_regbank`

## Requirements
- R1: A write changes nothing unless both `io_en` and `bm_en` are high. An ignored write never raises `wr_bad`.
- R2: Command, status and spare offsets accept only size 0. The pointer offset accepts only size 2. Offsets 5 to 7 accept nothing. An accepted write whose size does not fit leaves the registers unchanged and raises `wr_bad` for one cycle after the write edge.
- R3: While a channel's run bit is 1, a command write keeps the old direction bit (bit 3) and stores the other bits as written.
- R4: A command write that takes the run bit from 0 to 1 sets the active bit. In the cycle after the write edge, it pulses `dma_start[2*c+drv_sel[c]]` for one cycle, with the channel's pointer on `dma_ptr`.
- R5: A command write that takes the run bit from 1 to 0 clears the active bit. In the cycle after the write edge, it pulses `dma_abort[2*c+drv_sel[c]]` for one cycle. A write that leaves the run bit unchanged produces no pulse.
- R6: A status write never changes the active bit.
- R7: The interrupt and error bits are cleared only by writing 1 to them while they are set; writing 0 keeps them. Other status bits take the written value.
- R8: A pointer write stores the data with bits 1:0 forced to zero.
- R9: A `dma_done[c]` pulse clears channel c's run and active bits and sets its interrupt bit. `irq[c]` equals that interrupt bit.
- R10: After reset, every status byte reads 0x60 and every command, pointer and spare byte reads 0. No pulse and no interrupt is active.
- R11: When completion and a status write to the same channel land on the same edge, the completion effects win: the interrupt bit ends set.
- R12: `rd_data` returns, without delay, the four bytes at `rd_addr` to `rd_addr+3`, lowest byte first, wrapping inside the bank. Spare bytes read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | I/O decode enable |
| bm_en | input | 1 | Bus-master enable |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write byte address |
| wr_size | input | 2 | Write size code (0 byte, 1 half, 2 word) |
| wr_data | input | 32 | Write data, low byte first |
| wr_bad | output | 1 | Size or offset error on the last accepted write |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 32 | Four bytes from rd_addr upward |
| drv_sel | input | NUM_CH | Selected drive per channel |
| dma_start | output | 2*NUM_CH | Start pulse per drive |
| dma_abort | output | 2*NUM_CH | Abort pulse per drive |
| dma_ptr | output | 32*NUM_CH | Descriptor pointer per channel |
| dma_done | input | NUM_CH | Completion pulse per channel |
| irq | output | NUM_CH | Interrupt per channel |

## Verification
Engine completion and a software status write can reach the same channel on the same edge. The write may be trying to clear the very interrupt bit that the completion sets. The bench first raises the interrupt with a lone completion. It then drives a second completion together with a write-one-to-clear of that bit, and expects the interrupt to stay set. A later write alone must then clear it, which shows that the clear path itself works.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} xfer_size_e;
  typedef enum logic [2:0] {F_NONE, F_CMD, F_STAT, F_PTR, F_SPARE} field_e;

  localparam int CMD_RUN  = 0;
  localparam int CMD_DIR  = 3;
  localparam int STAT_ACT = 0;
  localparam int STAT_ERR = 1;
  localparam int STAT_IRQ = 2;
  localparam logic [7:0] STAT_RST = 8'h60;
  localparam int PTR_W = 32;
endpackage

// File: rtl/bmdma_wdecode.sv
module bmdma_wdecode
  import bmdma_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          wr_en,
  input  logic          io_en,
  input  logic          bm_en,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output field_e        fld,
  output logic          bad
);
  field_e want;
  logic   fits;
  logic   live;

  assign live = wr_en & io_en & bm_en;

  always_comb begin
    want = F_NONE;
    fits = 1'b0;
    unique case (addr[2:0])
      3'd0:        begin want = F_CMD;   fits = (size == SZ_BYTE); end
      3'd2:        begin want = F_STAT;  fits = (size == SZ_BYTE); end
      3'd1, 3'd3:  begin want = F_SPARE; fits = (size == SZ_BYTE); end
      3'd4:        begin want = F_PTR;   fits = (size == SZ_WORD); end
      default:     begin want = F_NONE;  fits = 1'b0; end
    endcase
    fld = (live && fits) ? want : F_NONE;
    bad = live && !fits;
  end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic             wr_stat,
  input  logic             wr_ptr,
  input  logic [7:0]       wr_byte,
  input  logic [PTR_W-1:0] wr_word,
  input  logic             dev_sel,
  input  logic             done,
  output logic [7:0]       cmd_q,
  output logic [7:0]       stat_q,
  output logic [PTR_W-1:0] ptr_q,
  output logic [1:0]       start_q,
  output logic [1:0]       abort_q
);
  logic [7:0] cmd_w, stat_w, cmd_n, stat_n;
  logic       go, halt;

  always_comb begin
    cmd_w = wr_byte;
    if (cmd_q[CMD_RUN]) cmd_w[CMD_DIR] = cmd_q[CMD_DIR];

    stat_w = wr_byte;
    stat_w[STAT_ACT] = stat_q[STAT_ACT];
    stat_w[STAT_ERR] = stat_q[STAT_ERR] & ~wr_byte[STAT_ERR];
    stat_w[STAT_IRQ] = stat_q[STAT_IRQ] & ~wr_byte[STAT_IRQ];

    cmd_n  = cmd_q;
    stat_n = stat_q;
    go     = 1'b0;
    halt   = 1'b0;
    if (wr_cmd) begin
      cmd_n = cmd_w;
      go    = cmd_w[CMD_RUN] & ~cmd_q[CMD_RUN];
      halt  = ~cmd_w[CMD_RUN] & cmd_q[CMD_RUN];
      if (go)   stat_n[STAT_ACT] = 1'b1;
      if (halt) stat_n[STAT_ACT] = 1'b0;
    end
    if (wr_stat) stat_n = stat_w;
    if (done) begin
      cmd_n[CMD_RUN]   = 1'b0;
      stat_n[STAT_ACT] = 1'b0;
      stat_n[STAT_IRQ] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      stat_q  <= STAT_RST;
      ptr_q   <= '0;
      start_q <= '0;
      abort_q <= '0;
    end else begin
      cmd_q   <= cmd_n;
      stat_q  <= stat_n;
      if (wr_ptr) ptr_q <= {wr_word[PTR_W-1:2], 2'b00};
      start_q <= go   ? (2'b01 << dev_sel) : 2'b00;
      abort_q <= halt ? (2'b01 << dev_sel) : 2'b00;
    end
  end
endmodule

// File: rtl/bmdma_regbank.sv
module bmdma_regbank
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int AW = $clog2(NUM_CH * 8),
  localparam int ND = NUM_CH * 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    io_en,
  input  logic                    bm_en,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [1:0]              wr_size,
  input  logic [31:0]             wr_data,
  output logic                    wr_bad,
  input  logic [AW-1:0]           rd_addr,
  output logic [31:0]             rd_data,
  input  logic [NUM_CH-1:0]       drv_sel,
  output logic [ND-1:0]           dma_start,
  output logic [ND-1:0]           dma_abort,
  output logic [NUM_CH*PTR_W-1:0] dma_ptr,
  input  logic [NUM_CH-1:0]       dma_done,
  output logic [NUM_CH-1:0]       irq
);
  localparam int CW = AW - 3;
  localparam int NB = NUM_CH * 8;

  field_e          fld;
  logic            bad_c;
  logic [CW-1:0]   wch;
  logic [NUM_CH*8-1:0] cmd_flat, stat_flat;
  logic [7:0]      spare_q [NUM_CH][2];
  logic [7:0]      img [NB];

  assign wch = wr_addr[AW-1:3];

  bmdma_wdecode #(.AW(AW)) u_dec (
    .wr_en(wr_en), .io_en(io_en), .bm_en(bm_en),
    .addr(wr_addr), .size(wr_size), .fld(fld), .bad(bad_c)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = (wch == CW'(c));
    bmdma_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_cmd(sel && fld == F_CMD),
      .wr_stat(sel && fld == F_STAT),
      .wr_ptr(sel && fld == F_PTR),
      .wr_byte(wr_data[7:0]), .wr_word(wr_data),
      .dev_sel(drv_sel[c]), .done(dma_done[c]),
      .cmd_q(cmd_flat[c*8 +: 8]), .stat_q(stat_flat[c*8 +: 8]),
      .ptr_q(dma_ptr[c*PTR_W +: PTR_W]),
      .start_q(dma_start[c*2 +: 2]), .abort_q(dma_abort[c*2 +: 2])
    );
    assign irq[c] = stat_flat[c*8 + STAT_IRQ];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        spare_q[c][0] <= '0;
        spare_q[c][1] <= '0;
      end else if (sel && fld == F_SPARE) begin
        spare_q[c][wr_addr[1]] <= wr_data[7:0];
      end
    end

    always_comb begin
      img[c*8 + 0] = cmd_flat[c*8 +: 8];
      img[c*8 + 1] = spare_q[c][0];
      img[c*8 + 2] = stat_flat[c*8 +: 8];
      img[c*8 + 3] = spare_q[c][1];
      for (int b = 0; b < 4; b++)
        img[c*8 + 4 + b] = dma_ptr[c*PTR_W + b*8 +: 8];
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++)
      rd_data[k*8 +: 8] = img[rd_addr + AW'(k)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_bad <= 1'b0;
    else        wr_bad <= bad_c;
  end
endmodule

// File: rtl/bmdma_regbank_chk.sv
module bmdma_regbank_chk #(
  parameter int NUM_CH = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                io_en,
  input logic                bm_en,
  input logic                wr_en,
  input logic                wr_bad,
  input logic [NUM_CH*2-1:0] dma_start,
  input logic [NUM_CH*2-1:0] dma_abort,
  input logic [NUM_CH-1:0]   dma_done,
  input logic [NUM_CH-1:0]   irq,
  input logic [NUM_CH*8-1:0] cmd_flat,
  input logic [NUM_CH*8-1:0] stat_flat,
  input logic [NUM_CH*32-1:0] dma_ptr
);
  assert_one_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dma_start | dma_abort));

  assert_gated_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(io_en && bm_en) && dma_done == '0)
      |=> ($stable(cmd_flat) && $stable(dma_ptr) && !wr_bad));

  assert_bad_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |-> $past(wr_en));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_done_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done[c] |=> (irq[c] && !cmd_flat[c*8] && !stat_flat[c*8]));
    assert_active_with_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_flat[c*8]) |-> (dma_start[c*2 +: 2] != 2'b00));
    assert_active_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_flat[c*8]) |-> (dma_abort[c*2 +: 2] != 2'b00 || $past(dma_done[c])));
  end
endmodule

bind bmdma_regbank bmdma_regbank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en), .wr_en(wr_en),
  .wr_bad(wr_bad), .dma_start(dma_start), .dma_abort(dma_abort),
  .dma_done(dma_done), .irq(irq), .cmd_flat(cmd_flat),
  .stat_flat(stat_flat), .dma_ptr(dma_ptr)
);

// File: tb/sim_bmdma_regbank.sv
module sim_bmdma_regbank;
  logic        clk = 0, rst_n = 0;
  logic        io_en = 0, bm_en = 0, wr_en = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 0;
  logic [1:0]  wr_size = 0;
  logic [31:0] wr_data = 0;
  logic        wr_bad;
  logic [31:0] rd_data;
  logic [1:0]  drv_sel = 0, dma_done = 0, irq;
  logic [3:0]  dma_start, dma_abort;
  logic [63:0] dma_ptr;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bmdma_regbank u0 (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data), .wr_bad(wr_bad),
    .rd_addr(rd_addr), .rd_data(rd_data), .drv_sel(drv_sel),
    .dma_start(dma_start), .dma_abort(dma_abort), .dma_ptr(dma_ptr),
    .dma_done(dma_done), .irq(irq)
  );

  // {wr_addr, wr_size, wr_data, rd_addr, expected rd_data}
  localparam logic [73:0] VEC [6] = '{
    {4'd4,  2'd2, 32'h12345677, 4'd4,  32'h12345674},  // R8
    {4'd0,  2'd0, 32'h00000008, 4'd0,  32'h00600008},  // R12
    {4'd1,  2'd0, 32'h000000A5, 4'd0,  32'h0060A508},  // R12 spare
    {4'd12, 2'd2, 32'hCAFEF00F, 4'd12, 32'hCAFEF00C},  // R8
    {4'd10, 2'd0, 32'h0000001F, 4'd8,  32'h00180000},  // R6 R7
    {4'd11, 2'd0, 32'h0000003C, 4'd8,  32'h3C180000}   // R12 spare
  };

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [1:0] s, logic [31:0] d, logic [1:0] dn);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_size = s; wr_data = d; dma_done = dn;
    @(negedge clk);
    wr_en = 0; dma_done = 0;
  endtask

  task automatic done_only(logic [1:0] dn);
    @(negedge clk);
    dma_done = dn;
    @(negedge clk);
    dma_done = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, v);  chk("R10 ch0 image", v, 32'h00600000);
    rd(8, v);  chk("R10 ch1 image", v, 32'h00600000);
    rd(4, v);  chk("R10 ptr0", v, 0);
    chk("R10 irq/pulses", {irq, dma_start, dma_abort}, 0);

    io_en = 1; bm_en = 1;
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][73:70], VEC[i][69:68], VEC[i][67:36], 2'b00);
      rd(VEC[i][35:32], v);
      chk("R12 vector table", v, VEC[i][31:0]);
    end

    // R4 start on drive 1 of channel 0, direction may change while idle
    drv_sel = 2'b01;
    wr(0, 0, 32'h01, 0);
    chk("R4 start pulse", dma_start, 4'b0010);
    chk("R4 ptr handed over", dma_ptr[31:0], 32'h12345674);
    rd(0, v); chk("R4 active set", v, 32'h0061A501);
    @(negedge clk);
    chk("R4 single pulse", dma_start, 0);

    // R3 direction locked while running
    wr(0, 0, 32'h09, 0);
    rd(0, v); chk("R3 dir locked", v, 32'h0061A501);
    chk("R5 no pulse w/o edge", {dma_start, dma_abort}, 0);

    // R6 active cannot be written
    wr(2, 0, 32'h60, 0);
    rd(0, v); chk("R6 active kept", v, 32'h0061A501);

    // R5 abort
    wr(0, 0, 32'h00, 0);
    chk("R5 abort pulse", dma_abort, 4'b0010);
    rd(0, v); chk("R5 active cleared", v, 32'h0060A500);

    // R9 completion
    drv_sel = 2'b00;
    wr(0, 0, 32'h01, 0);
    chk("R4 start drive0", dma_start, 4'b0001);
    done_only(2'b01);
    rd(0, v); chk("R9 done clears run/act sets irq", v, 32'h0064A500);
    chk("R9 irq out", irq, 2'b01);

    // R7 write-one-to-clear
    wr(2, 0, 32'h60, 0);
    rd(0, v); chk("R7 zero keeps irq", v, 32'h0064A500);
    wr(2, 0, 32'h64, 0);
    rd(0, v); chk("R7 one clears irq", v, 32'h0060A500);
    chk("R7 irq low", irq, 2'b00);

    // R1 gating
    bm_en = 0;
    wr(8, 0, 32'h01, 0);
    chk("R1 no start when bm off", {dma_start, wr_bad}, 0);
    rd(8, v); chk("R1 cmd unchanged", v, 32'h3C180000);
    bm_en = 1; io_en = 0;
    wr(12, 2, 32'h11111110, 0);
    rd(12, v); chk("R1 ptr unchanged", v, 32'hCAFEF00C);
    wr(12, 1, 32'h0, 0);
    chk("R1 no error when ignored", wr_bad, 0);
    io_en = 1;

    // R2 size rules
    wr(0, 1, 32'h0001, 0);
    chk("R2 half to cmd flagged", wr_bad, 1);
    chk("R2 no start", dma_start, 0);
    rd(0, v); chk("R2 cmd unchanged", v, 32'h0060A500);
    wr(4, 0, 32'hFF, 0);
    chk("R2 byte to ptr flagged", wr_bad, 1);
    rd(4, v); chk("R2 ptr unchanged", v, 32'h12345674);
    wr(5, 0, 32'hFF, 0);
    chk("R2 offset 5 flagged", wr_bad, 1);

    // R11 completion vs status write on the same edge
    drv_sel = 2'b10;
    wr(8, 0, 32'h01, 0);
    chk("R4 start ch1 drive1", dma_start, 4'b1000);
    chk("R4 ptr ch1", dma_ptr[63:32], 32'hCAFEF00C);
    done_only(2'b10);
    rd(8, v); chk("R9 ch1 done", v, 32'h3C1C0000);
    wr(10, 0, 32'h1C, 2'b10);
    rd(8, v); chk("R11 done wins over clear", v, 32'h3C1C0000);
    chk("R11 irq held", irq, 2'b10);
    wr(10, 0, 32'h1C, 0);
    rd(8, v); chk("R7 ch1 clear", v, 32'h3C180000);
    chk("R7 ch1 irq low", irq, 2'b00);

    finished = 1;
    summary();
  end
endmodule